// File: doc/BRIEF.md
# Hardware Multithreading Thread Selector

This block decides, on every clock cycle, which of several hardware thread contexts may place an instruction into a single-issue pipeline. Each context has its own register state held elsewhere, so moving from one context to another costs no extra cycles. The selector only names the context that issues and marks whether an issue happens at all. Fetch, register files and execution units sit outside it.

Two scheduling modes are available through one select input. In interleaved mode the selector rotates among eligible contexts, one pick per cycle. The search starts just after the context that issued last. In block mode the context that issued last keeps the pipeline until it reports a long-latency stall, such as a cache miss or a page fault. Only then does the selector move on. A context that reported a long stall stays parked until its data-return event arrives. When nothing is eligible, the selector inserts a bubble. Every issued instruction carries its thread number down a tag pipeline of configurable depth, so each stage knows which context owns it.

Top module: `hmt_thread_select`

## Requirements
- R1: In block mode (`modeBlock`=1), if the context that issued last is still ready, has no short stall and is not parked, the selector issues from it again.
- R2: A long-stall event (`stallEvt` with `stallId`) parks that context from the next cycle on, and a parked context is never selected. The context may still issue in the cycle the event is presented.
- R3: A data-return event (`retEvt` with `retId`) unparks the context, which becomes eligible in the following cycle. It is not eligible in the cycle of the return itself.
- R4: In interleaved mode (`modeBlock`=0), the selector picks the first eligible context found by a circular search that starts at the thread after the one that issued last. With all contexts eligible, the issue order is therefore 0,1,2,3,0 for four threads.
- R5: A context is eligible only when its `threadReady` bit is 1, its `threadStall` bit is 0 and it is not parked. Ineligible contexts are skipped, and a single eligible context issues on consecutive cycles.
- R6: When no context can issue, `issueValid` is 0, a bubble enters the pipeline, and the last-issued context is left unchanged.
- R7: If a long-stall event and a data-return event name the same context in the same cycle, the return wins and the context is not parked.
- R8: In block mode, once the current context is parked or not ready, the selector switches on the very next cycle to the first eligible context after it, in circular order.
- R9: Tag stage 0 holds the valid flag and thread number of the previous cycle's issue, and stage i holds what stage i-1 held one cycle earlier. Stage i of `pipeTag` occupies bits [i*TID_W +: TID_W].
- R10: In block mode, a short stall (`threadStall`) on the current context inserts bubbles without switching away from it. It issues again once the stall clears.
- R11: After reset, all tag stages are invalid, no context is parked, and the first search begins at thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeBlock | input | 1 | 1 = block (switch on long stall), 0 = interleaved |
| threadReady | input | NUM_THREADS | Per-context has-work flag |
| threadStall | input | NUM_THREADS | Per-context short stall flag |
| stallEvt | input | 1 | Long-latency stall event strobe |
| stallId | input | TID_W | Context that reported the long stall |
| retEvt | input | 1 | Data-return event strobe |
| retId | input | TID_W | Context whose data returned |
| selThread | output | TID_W | Context selected this cycle |
| issueValid | output | 1 | An instruction issues this cycle |
| pipeValid | output | PIPE_DEPTH | Per-stage valid of the tag pipeline |
| pipeTag | output | PIPE_DEPTH*TID_W | Per-stage owning thread number |

## Verification
The assertions assume that each event kind names at most one context per cycle, and that the event identifiers are always within the thread count. A return arriving for a context that is not parked is treated as harmless. The stimulus only ever drives a single stall identifier and a single return identifier, always below four. It raises each event for exactly one cycle and pairs every long stall with a later return, except where a test needs a context to stay parked. Inputs change only just after a rising edge, so the combinational selection is stable whenever it is sampled.

// File: rtl/hmt_sel_pkg.sv
package hmt_sel_pkg;

  // Strobes from the scheduling control to the state-holding datapath.
  typedef struct packed {
    logic issueEn;   // an instruction issues this cycle
    logic setWait;   // park the context named by the stall event
    logic clrWait;   // unpark the context named by the return event
  } selStrobe_t;

endpackage

// File: rtl/hmt_rr_pick.sv
module hmt_rr_pick #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic [IDX_W-1:0]   lastIdx,
  output logic               found,
  output logic [IDX_W-1:0]   pickIdx
);

  // Circular search over offsets 1..NUM_REQ from lastIdx; offset NUM_REQ
  // returns to lastIdx itself, so a lone requester is still picked.
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int k = 1; k <= NUM_REQ; k++) begin
      int cand;
      cand = (int'(lastIdx) + k) % NUM_REQ;
      if (!found && reqVec[cand]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/hmt_sel_ctrl.sv
module hmt_sel_ctrl
  import hmt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   modeBlock,
  input  logic [NUM_THREADS-1:0] threadReady,
  input  logic [NUM_THREADS-1:0] threadStall,
  input  logic [NUM_THREADS-1:0] waitVec,
  input  logic [TID_W-1:0]       lastThread,
  input  logic                   stallEvt,
  input  logic [TID_W-1:0]       stallId,
  input  logic                   retEvt,
  input  logic [TID_W-1:0]       retId,
  output selStrobe_t             strobe,
  output logic [TID_W-1:0]       selId
);

  logic [NUM_THREADS-1:0] eligVec;
  logic                   rrFound;
  logic [TID_W-1:0]       rrIdx;
  logic                   holdCur;

  assign eligVec = threadReady & ~threadStall & ~waitVec;

  hmt_rr_pick #(.NUM_REQ(NUM_THREADS)) u_pick (
    .reqVec (eligVec),
    .lastIdx(lastThread),
    .found  (rrFound),
    .pickIdx(rrIdx)
  );

  // Block mode keeps the current context while it has work and is not parked.
  assign holdCur = modeBlock && threadReady[lastThread] && !waitVec[lastThread];

  always_comb begin
    if (holdCur) begin
      strobe.issueEn = !threadStall[lastThread];
      selId          = lastThread;
    end else begin
      strobe.issueEn = rrFound;
      selId          = rrIdx;
    end
    // Return beats a stall naming the same context.
    strobe.clrWait = retEvt;
    strobe.setWait = stallEvt && !(retEvt && (retId == stallId));
  end

endmodule

// File: rtl/hmt_sel_dp.sv
module hmt_sel_dp
  import hmt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PIPE_DEPTH = 5,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  selStrobe_t                  strobe,
  input  logic [TID_W-1:0]            selId,
  input  logic [TID_W-1:0]            stallId,
  input  logic [TID_W-1:0]            retId,
  output logic [NUM_THREADS-1:0]      waitVec,
  output logic [TID_W-1:0]            lastThread,
  output logic [PIPE_DEPTH-1:0]       pipeValid,
  output logic [PIPE_DEPTH*TID_W-1:0] pipeTag
);

  // Park flags, one per context.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_wait
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        waitVec[t] <= 1'b0;
      end else if (strobe.clrWait && (int'(retId) == t)) begin
        waitVec[t] <= 1'b0;
      end else if (strobe.setWait && (int'(stallId) == t)) begin
        waitVec[t] <= 1'b1;
      end
    end
  end

  // Last issuing context; reset value makes the first search start at 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastThread <= TID_W'(NUM_THREADS - 1);
    end else if (strobe.issueEn) begin
      lastThread <= selId;
    end
  end

  // Thread tag pipeline.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipeValid[0]        <= 1'b0;
      pipeTag[0 +: TID_W] <= '0;
    end else begin
      pipeValid[0]        <= strobe.issueEn;
      pipeTag[0 +: TID_W] <= selId;
    end
  end

  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pipeValid[s]            <= 1'b0;
        pipeTag[s*TID_W +: TID_W] <= '0;
      end else begin
        pipeValid[s]            <= pipeValid[s-1];
        pipeTag[s*TID_W +: TID_W] <= pipeTag[(s-1)*TID_W +: TID_W];
      end
    end
  end

endmodule

// File: rtl/hmt_thread_select.sv
module hmt_thread_select
  import hmt_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int PIPE_DEPTH = 5,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        modeBlock,
  input  logic [NUM_THREADS-1:0]      threadReady,
  input  logic [NUM_THREADS-1:0]      threadStall,
  input  logic                        stallEvt,
  input  logic [TID_W-1:0]            stallId,
  input  logic                        retEvt,
  input  logic [TID_W-1:0]            retId,
  output logic [TID_W-1:0]            selThread,
  output logic                        issueValid,
  output logic [PIPE_DEPTH-1:0]       pipeValid,
  output logic [PIPE_DEPTH*TID_W-1:0] pipeTag
);

  selStrobe_t             strobe;
  logic [NUM_THREADS-1:0] waitVec;
  logic [TID_W-1:0]       lastThread;

  hmt_sel_ctrl #(.NUM_THREADS(NUM_THREADS)) u_ctrl (
    .modeBlock  (modeBlock),
    .threadReady(threadReady),
    .threadStall(threadStall),
    .waitVec    (waitVec),
    .lastThread (lastThread),
    .stallEvt   (stallEvt),
    .stallId    (stallId),
    .retEvt     (retEvt),
    .retId      (retId),
    .strobe     (strobe),
    .selId      (selThread)
  );

  hmt_sel_dp #(.NUM_THREADS(NUM_THREADS), .PIPE_DEPTH(PIPE_DEPTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .selId     (selThread),
    .stallId   (stallId),
    .retId     (retId),
    .waitVec   (waitVec),
    .lastThread(lastThread),
    .pipeValid (pipeValid),
    .pipeTag   (pipeTag)
  );

  assign issueValid = strobe.issueEn;

endmodule

// File: rtl/hmt_thread_select_chk.sv
module hmt_thread_select_chk #(
  parameter int NUM_THREADS = 4,
  parameter int PIPE_DEPTH = 5,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        modeBlock,
  input logic [NUM_THREADS-1:0]      threadReady,
  input logic [NUM_THREADS-1:0]      threadStall,
  input logic                        stallEvt,
  input logic [TID_W-1:0]            stallId,
  input logic                        retEvt,
  input logic [TID_W-1:0]            retId,
  input logic [TID_W-1:0]            selThread,
  input logic                        issueValid,
  input logic [PIPE_DEPTH-1:0]       pipeValid,
  input logic [PIPE_DEPTH*TID_W-1:0] pipeTag,
  input logic [NUM_THREADS-1:0]      waitVec,
  input logic [TID_W-1:0]            lastThread
);

  logic [NUM_THREADS-1:0] eligNow;
  assign eligNow = threadReady & ~threadStall & ~waitVec;

  assert_issue_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issueValid |-> (threadReady[selThread] && !waitVec[selThread]));

  assert_parked_not_chosen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stallEvt && !(retEvt && retId == stallId))
      |=> !(issueValid && selThread == $past(stallId)));

  assert_return_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stallEvt && retEvt && retId == stallId) |=> !waitVec[$past(retId)]);

  assert_block_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && modeBlock && $past(modeBlock) && $past(issueValid)
      && threadReady[$past(selThread)] && !threadStall[$past(selThread)]
      && !($past(stallEvt) && $past(stallId) == $past(selThread)))
      |-> (issueValid && selThread == $past(selThread)));

  assert_short_stall_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBlock && threadReady[lastThread] && !waitVec[lastThread]
      && threadStall[lastThread]) |-> !issueValid);

  assert_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !modeBlock && $past(issueValid) && issueValid
      && $countones(eligNow) > 1) |-> selThread != $past(selThread));

  assert_bubble_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeBlock && !issueValid) |-> eligNow == '0);

  assert_stage0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pipeValid[0] == $past(issueValid)
      && (!pipeValid[0] || pipeTag[0 +: TID_W] == $past(selThread))));

  for (genvar s = 1; s < PIPE_DEPTH; s++) begin : g_stage_chk
    assert_stage_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pipeValid[s] == $past(pipeValid[s-1])
        && pipeTag[s*TID_W +: TID_W] == $past(pipeTag[(s-1)*TID_W +: TID_W])));
  end

endmodule

bind hmt_thread_select hmt_thread_select_chk #(
  .NUM_THREADS(NUM_THREADS), .PIPE_DEPTH(PIPE_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .modeBlock(modeBlock), .threadReady(threadReady),
  .threadStall(threadStall), .stallEvt(stallEvt), .stallId(stallId),
  .retEvt(retEvt), .retId(retId), .selThread(selThread), .issueValid(issueValid),
  .pipeValid(pipeValid), .pipeTag(pipeTag), .waitVec(waitVec), .lastThread(lastThread)
);

// File: tb/hmt_thread_select_test.sv
module hmt_thread_select_test;

  localparam int NT = 4;
  localparam int PD = 5;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          modeBlock = 1'b0;
  logic [NT-1:0] threadReady = '0;
  logic [NT-1:0] threadStall = '0;
  logic          stallEvt = 1'b0;
  logic [TW-1:0] stallId = '0;
  logic          retEvt = 1'b0;
  logic [TW-1:0] retId = '0;
  logic [TW-1:0] selThread;
  logic          issueValid;
  logic [PD-1:0] pipeValid;
  logic [PD*TW-1:0] pipeTag;

  always #2.5 clk = ~clk;

  hmt_thread_select #(.NUM_THREADS(NT), .PIPE_DEPTH(PD)) uut (
    .clk(clk), .rst_n(rst_n), .modeBlock(modeBlock), .threadReady(threadReady),
    .threadStall(threadStall), .stallEvt(stallEvt), .stallId(stallId),
    .retEvt(retEvt), .retId(retId), .selThread(selThread), .issueValid(issueValid),
    .pipeValid(pipeValid), .pipeTag(pipeTag)
  );

  typedef struct {
    bit    v;
    int    s;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t hist[PD];
  int  errors = 0;
  int  checks = 0;
  bit  doneRun = 0;

  // Driver: apply one cycle of stimulus and queue the expected issue.
  task automatic drive(input bit mb, input logic [NT-1:0] rdy, input logic [NT-1:0] stl,
                       input bit se, input int sid, input bit re, input int rid,
                       input bit ev, input int es, input string req);
    expItem_t it;
    @(posedge clk);
    #1;
    modeBlock   = mb;
    threadReady = rdy;
    threadStall = stl;
    stallEvt    = se;
    stallId     = TW'(sid);
    retEvt      = re;
    retId       = TW'(rid);
    it.v = ev; it.s = es; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compare issue and tag pipeline away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !doneRun) begin
      expItem_t cur;
      for (int i = 0; i < PD; i++) begin
        checks++;
        if (pipeValid[i] !== hist[i].v ||
            (hist[i].v && int'(pipeTag[i*TW +: TW]) != hist[i].s)) begin
          errors++;
          $display("FAIL R9 stage %0d: valid=%0b tag=%0d expected valid=%0b tag=%0d",
                   i, pipeValid[i], pipeTag[i*TW +: TW], hist[i].v, hist[i].s);
        end
      end
      if (expQ.size() > 0) begin
        cur = expQ.pop_front();
        checks++;
        if (issueValid !== cur.v || (cur.v && int'(selThread) != cur.s)) begin
          errors++;
          $display("FAIL %s: valid=%0b sel=%0d expected valid=%0b sel=%0d",
                   cur.req, issueValid, selThread, cur.v, cur.s);
        end
      end else begin
        cur.v = 0; cur.s = 0; cur.req = "idle";
      end
      for (int i = PD - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = cur;
    end
  end

  initial begin
    for (int i = 0; i < PD; i++) begin hist[i].v = 0; hist[i].s = 0; hist[i].req = ""; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pipeValid !== '0) begin
      errors++;
      $display("FAIL R11 reset: pipeValid=%b expected=%b", pipeValid, {PD{1'b0}});
    end
    @(posedge clk); #1; rst_n = 1'b1;

    // Interleaved rotation from reset (R11, R4)
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 0, "R11 first pick");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R4");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 2, "R4");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 3, "R4");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 0, "R4 wrap");
    // Skipping short-stalled contexts (R5)
    drive(0, 4'b1111, 4'b0101, 0,0,0,0, 1, 1, "R5 skip");
    drive(0, 4'b1111, 4'b0101, 0,0,0,0, 1, 3, "R5 skip");
    drive(0, 4'b1111, 4'b0101, 0,0,0,0, 1, 1, "R5 skip");
    // Lone ready context repeats (R5)
    drive(0, 4'b0100, 4'b0000, 0,0,0,0, 1, 2, "R5 single");
    drive(0, 4'b0100, 4'b0000, 0,0,0,0, 1, 2, "R5 single");
    // Nothing eligible (R6)
    drive(0, 4'b0000, 4'b0000, 0,0,0,0, 0, 0, "R6 bubble");
    drive(0, 4'b0000, 4'b0000, 0,0,0,0, 0, 0, "R6 bubble");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 3, "R6 resume after last");
    // Long stall parks thread 0 (R2), return unparks (R3)
    drive(0, 4'b1111, 4'b0000, 1,0,0,0, 1, 0, "R2 event cycle");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R2");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 2, "R2");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 3, "R2");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R2 parked skipped");
    drive(0, 4'b1111, 4'b0000, 0,0,1,0, 1, 2, "R3 return cycle");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 3, "R3");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 0, "R3 eligible again");
    // Same-cycle stall and return on thread 1 (R7)
    drive(0, 4'b1111, 4'b0000, 1,1,1,1, 1, 1, "R7 event cycle");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 2, "R7");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 3, "R7");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 0, "R7");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R7 not parked");
    // Block mode (R1, R10, R8)
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R1 hold");
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R1 hold");
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R1 hold");
    drive(1, 4'b1111, 4'b0010, 0,0,0,0, 0, 0, "R10 bubble");
    drive(1, 4'b1111, 4'b0010, 0,0,0,0, 0, 0, "R10 bubble");
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R10 no switch");
    drive(1, 4'b1111, 4'b0000, 1,1,0,0, 1, 1, "R8 event cycle");
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 2, "R8 switch");
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 2, "R1 hold new");
    drive(1, 4'b1011, 4'b0000, 0,0,0,0, 1, 3, "R8 not ready");
    drive(1, 4'b1111, 4'b0000, 0,0,1,1, 1, 3, "R1 hold");
    drive(1, 4'b1111, 4'b0000, 1,3,0,0, 1, 3, "R8 event cycle");
    drive(1, 4'b1111, 4'b0000, 0,0,0,0, 1, 0, "R8 wrap switch");
    drive(1, 4'b1111, 4'b0000, 0,0,1,3, 1, 0, "R1 hold");
    // Back to interleaved with a parked-free set
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 1, "R4");
    drive(0, 4'b1111, 4'b0000, 0,0,0,0, 1, 2, "R4");
    drive(0, 4'b0000, 4'b0000, 0,0,0,0, 0, 0, "R6 bubble");

    repeat (PD + 2) drive(0, 4'b0000, 4'b0000, 0,0,0,0, 0, 0, "R6 drain");
    @(posedge clk);
    @(negedge clk);
    #1;
    doneRun = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneRun) begin
      doneRun = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule